// File: doc/BRIEF.md
# Two-Buffer LCD Frame Fetch Sequencer

This block reads display frame data from memory, one 16-bit word at a time, and hands each word to an LCD controller over a valid/ready stream. Software describes up to two frame buffers. Each buffer has an inclusive first and last byte address. Each 32-bit address is loaded as two 16-bit register halves. The sequencer walks a buffer from its first address to its last in 2-byte steps. It then either wraps to the same buffer (single-buffer mode) or moves to the other buffer (dual-buffer mode), in a ping-pong pattern.

Fetching starts only after the LCD controller raises its enable input. When a buffer is finished, the sequencer sets a read-only end flag and can pulse the interrupt line. The end flag clears by itself once the next buffer's first read is accepted, so the next end of that buffer can be seen again. If a memory response returns with its error flag set, the sequencer records the error, can pulse the interrupt line, and stops reading until enable is taken low and then high again. A two-bit source selector chooses which memory port supplies the data. The sequencer only stores this selector and drives it out.

Top module: `lcd_frame_dma`

## Requirements
- R1: After reset, memReqValid, pixValid and irq are 0, every register reads 0 and srcSel is 0.
- R2: Register 0 is the control word. Bit 0 is mode (1 = dual buffer). Bit 1 is the buffer-end interrupt enable. Bit 2 is the bus-error interrupt enable. Bits 3, 4 and 5 are read-only flags for end of buffer 1, end of buffer 2 and bus error. Bits 7:6 are the source select. Writes to bits 3 to 5 and 15:8 are ignored. Registers 1 to 8 read back as written. They hold, in this order, the upper and lower halves of: buffer-1 first address, buffer-1 last address, buffer-2 first address, buffer-2 last address.
- R3: No memory read is requested before lcdEnable is high.
- R4: Within a buffer, read addresses run from the first address to the last address inclusive, in steps of 2. A request holds its address until it is accepted. Every word returned without error appears on pixData, in request order.
- R5: In dual-buffer mode, buffer 1's last word is followed by buffer 2's first address, and buffer 2's last word is followed by buffer 1's first address.
- R6: In single-buffer mode, buffer 1's last word is followed by buffer 1's first address, and the buffer-2 registers are not used.
- R7: Flag bit 3 (or bit 4 for buffer 2) reads 1 in the cycle after that buffer's last word is accepted on the pixel stream. It reads 0 again once the next memory read is accepted.
- R8: irq is a single-cycle pulse. It occurs in the cycle after a buffer's last word is accepted, only when bit 1 is set. No pulse occurs when bit 1 is clear.
- R9: While pixValid is high and pixReady is low, pixData stays stable and no new read is requested.
- R10: An error response produces no pixel and sets flag bit 5. It pulses irq when bit 2 is set. No further read is requested while lcdEnable stays high.
- R11: When lcdEnable goes low, at most the word in flight is delivered and requests then stop. The next rise of lcdEnable restarts at buffer 1's first address and clears bit 5.
- R12: srcSel always equals control bits 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register select for read and write |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| lcdEnable | input | 1 | Fetch enable from the LCD controller |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory read request accepted |
| memReqAddr | output | 32 | Byte address of the requested word |
| memRspValid | input | 1 | Memory response valid |
| memRspErr | input | 1 | Memory response carries an error |
| memRspData | input | 16 | Memory response word |
| pixValid | output | 1 | Pixel word valid |
| pixReady | input | 1 | Pixel word accepted |
| pixData | output | 16 | Pixel word |
| srcSel | output | 2 | Memory port select |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench uses the default parameters: 16-bit registers, 32-bit addresses and 16-bit words. Buffer 1 is set to four words and buffer 2 to two words. With buffers this short, every pixel of several full ping-pong periods can be checked against an address-derived data pattern in a few dozen cycles. Each buffer-end flag and interrupt is observed many times. The bench also runs the sequence with the request side and the pixel side both throttled. Short buffers also let the bench place an error response at a chosen word and then check the restart that follows.

// File: rtl/lcd_frame_dma_pkg.sv
package lcd_frame_dma_pkg;
  // control word bit positions
  localparam int unsigned B_MODE  = 0;
  localparam int unsigned B_BLKIE = 1;
  localparam int unsigned B_ERRIE = 2;
  localparam int unsigned B_BLK1  = 3;
  localparam int unsigned B_BLK2  = 4;
  localparam int unsigned B_ERR   = 5;
  localparam int unsigned SRC_LSB = 6;
  // bound registers: 0 first1, 1 last1, 2 first2, 3 last2
  localparam int unsigned NUM_BOUNDS = 4;

  typedef struct packed {
    logic loadTop1;
    logic loadTop2;
    logic advance;
    logic capture;
    logic clrBlk;
    logic setBlk1;
    logic setBlk2;
    logic setErr;
    logic clrErr;
  } seqStrobes_t;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WAIT, S_OUT, S_HALT
  } seqState_t;
endpackage

// File: rtl/lcd_frame_dma_ctrl.sv
module lcd_frame_dma_ctrl
  import lcd_frame_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lcdEnable,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        memRspErr,
  input  logic        pixReady,
  input  logic        atBottom,
  input  logic        twoBlock,
  input  logic        onBlock2,
  output logic        memReqValid,
  output logic        pixValid,
  output seqStrobes_t strobes
);
  seqState_t state, nextState;
  logic armed;
  logic start;

  assign start       = (state == S_IDLE) && lcdEnable && armed;
  assign memReqValid = (state == S_REQ);
  assign pixValid    = (state == S_OUT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      armed <= 1'b1;
    end else begin
      state <= nextState;
      if (!lcdEnable)  armed <= 1'b1;
      else if (start)  armed <= 1'b0;
    end
  end

  always_comb begin
    strobes   = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (start) begin
        strobes.loadTop1 = 1'b1;
        strobes.clrErr   = 1'b1;
        nextState        = S_REQ;
      end
      S_REQ: if (memReqReady) begin
        strobes.clrBlk = 1'b1;
        nextState      = S_WAIT;
      end
      S_WAIT: if (memRspValid) begin
        if (memRspErr) begin
          strobes.setErr = 1'b1;
          nextState      = S_HALT;
        end else begin
          strobes.capture = 1'b1;
          nextState       = S_OUT;
        end
      end
      S_OUT: if (pixReady) begin
        if (!atBottom) begin
          strobes.advance = 1'b1;
        end else if (twoBlock && !onBlock2) begin
          strobes.loadTop2 = 1'b1;
          strobes.setBlk1  = 1'b1;
        end else begin
          strobes.loadTop1 = 1'b1;
          strobes.setBlk1  = !onBlock2;
          strobes.setBlk2  = onBlock2;
        end
        nextState = (lcdEnable && !armed) ? S_REQ : S_IDLE;
      end
      S_HALT: if (armed) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/lcd_frame_dma_dp.sv
module lcd_frame_dma_dp
  import lcd_frame_dma_pkg::*;
#(
  parameter int unsigned REG_W    = 16,
  parameter int unsigned REGSEL_W = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SRC_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REGSEL_W-1:0]   regAddr,
  input  logic [REG_W-1:0]      regWrData,
  output logic [REG_W-1:0]      regRdData,
  input  seqStrobes_t           strobes,
  input  logic [DATA_W-1:0]     rspData,
  output logic                  atBottom,
  output logic                  twoBlock,
  output logic                  onBlock2,
  output logic [2*REG_W-1:0]    reqAddr,
  output logic [DATA_W-1:0]     pixData,
  output logic [SRC_W-1:0]      srcSel,
  output logic                  irq
);
  localparam int unsigned ADDR_W = 2 * REG_W;
  localparam int unsigned STEP   = DATA_W / 8;

  logic [NUM_BOUNDS-1:0][ADDR_W-1:0] bounds;
  logic              blkIe, errIe;
  logic              blk1Flag, blk2Flag, errFlag;
  logic [ADDR_W-1:0] curAddr;
  logic [REG_W-1:0]  ctrlWord;
  logic              ctrlWr;

  assign ctrlWr = regWrEn && (regAddr == '0);

  for (genvar k = 0; k < NUM_BOUNDS; k++) begin : g_bound
    logic [ADDR_W-1:0] bnd;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bnd <= '0;
      end else if (regWrEn) begin
        if (regAddr == REGSEL_W'(2*k+1)) bnd[ADDR_W-1:REG_W] <= regWrData;
        if (regAddr == REGSEL_W'(2*k+2)) bnd[REG_W-1:0]      <= regWrData;
      end
    end
    assign bounds[k] = bnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      twoBlock <= 1'b0;
      blkIe    <= 1'b0;
      errIe    <= 1'b0;
      srcSel   <= '0;
    end else if (ctrlWr) begin
      twoBlock <= regWrData[B_MODE];
      blkIe    <= regWrData[B_BLKIE];
      errIe    <= regWrData[B_ERRIE];
      srcSel   <= regWrData[SRC_LSB +: SRC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      onBlock2 <= 1'b0;
      pixData  <= '0;
      blk1Flag <= 1'b0;
      blk2Flag <= 1'b0;
      errFlag  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (strobes.loadTop1) begin
        curAddr  <= bounds[0];
        onBlock2 <= 1'b0;
      end else if (strobes.loadTop2) begin
        curAddr  <= bounds[2];
        onBlock2 <= 1'b1;
      end else if (strobes.advance) begin
        curAddr  <= curAddr + ADDR_W'(STEP);
      end
      if (strobes.capture) pixData <= rspData;
      if (strobes.clrBlk) begin
        blk1Flag <= 1'b0;
        blk2Flag <= 1'b0;
      end
      if (strobes.setBlk1) blk1Flag <= 1'b1;
      if (strobes.setBlk2) blk2Flag <= 1'b1;
      if (strobes.clrErr)  errFlag  <= 1'b0;
      if (strobes.setErr)  errFlag  <= 1'b1;
      irq <= (blkIe && (strobes.setBlk1 || strobes.setBlk2)) ||
             (errIe && strobes.setErr);
    end
  end

  assign reqAddr  = curAddr;
  assign atBottom = (curAddr == (onBlock2 ? bounds[3] : bounds[1]));

  always_comb begin
    ctrlWord                      = '0;
    ctrlWord[B_MODE]              = twoBlock;
    ctrlWord[B_BLKIE]             = blkIe;
    ctrlWord[B_ERRIE]             = errIe;
    ctrlWord[B_BLK1]              = blk1Flag;
    ctrlWord[B_BLK2]              = blk2Flag;
    ctrlWord[B_ERR]               = errFlag;
    ctrlWord[SRC_LSB +: SRC_W]    = srcSel;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == '0) regRdData = ctrlWord;
    for (int k = 0; k < NUM_BOUNDS; k++) begin
      if (regAddr == REGSEL_W'(2*k+1)) regRdData = bounds[k][ADDR_W-1:REG_W];
      if (regAddr == REGSEL_W'(2*k+2)) regRdData = bounds[k][REG_W-1:0];
    end
  end
endmodule

// File: rtl/lcd_frame_dma.sv
module lcd_frame_dma
  import lcd_frame_dma_pkg::*;
#(
  parameter int unsigned REG_W    = 16,
  parameter int unsigned REGSEL_W = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SRC_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REGSEL_W-1:0] regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic                lcdEnable,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [2*REG_W-1:0]  memReqAddr,
  input  logic                memRspValid,
  input  logic                memRspErr,
  input  logic [DATA_W-1:0]   memRspData,
  output logic                pixValid,
  input  logic                pixReady,
  output logic [DATA_W-1:0]   pixData,
  output logic [SRC_W-1:0]    srcSel,
  output logic                irq
);
  seqStrobes_t strobes;
  logic atBottom, twoBlock, onBlock2;

  lcd_frame_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lcdEnable(lcdEnable),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspErr(memRspErr),
    .pixReady(pixReady), .atBottom(atBottom), .twoBlock(twoBlock),
    .onBlock2(onBlock2), .memReqValid(memReqValid), .pixValid(pixValid),
    .strobes(strobes)
  );

  lcd_frame_dma_dp #(
    .REG_W(REG_W), .REGSEL_W(REGSEL_W), .DATA_W(DATA_W), .SRC_W(SRC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobes(strobes),
    .rspData(memRspData), .atBottom(atBottom), .twoBlock(twoBlock),
    .onBlock2(onBlock2), .reqAddr(memReqAddr), .pixData(pixData),
    .srcSel(srcSel), .irq(irq)
  );
endmodule

// File: rtl/lcd_frame_dma_chk.sv
module lcd_frame_dma_chk #(
  parameter int unsigned REG_W    = 16,
  parameter int unsigned REGSEL_W = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SRC_W    = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [REGSEL_W-1:0] regAddr,
  input logic [REG_W-1:0]    regRdData,
  input logic                lcdEnable,
  input logic                memReqValid,
  input logic                memReqReady,
  input logic [2*REG_W-1:0]  memReqAddr,
  input logic                memRspValid,
  input logic                memRspErr,
  input logic                pixValid,
  input logic                pixReady,
  input logic [DATA_W-1:0]   pixData,
  input logic [SRC_W-1:0]    srcSel,
  input logic                irq
);
  logic errSeen;

  always_ff @(posedge clk) begin
    if (!rstN)                         errSeen <= 1'b0;
    else if (!lcdEnable)               errSeen <= 1'b0;
    else if (memRspValid && memRspErr) errSeen <= 1'b1;
  end

  // R9
  pix_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && !pixReady |=> pixValid && $stable(pixData));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    errSeen |-> !memReqValid);

  // R12
  src_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == '0) |-> (regRdData[7:6] == srcSel));
endmodule

bind lcd_frame_dma lcd_frame_dma_chk #(
  .REG_W(REG_W), .REGSEL_W(REGSEL_W), .DATA_W(DATA_W), .SRC_W(SRC_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .lcdEnable(lcdEnable), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspErr(memRspErr),
  .pixValid(pixValid), .pixReady(pixReady), .pixData(pixData),
  .srcSel(srcSel), .irq(irq)
);

// File: tb/lcd_frame_dma_tb.sv
module lcd_frame_dma_tb;
  localparam logic [31:0] TOP1 = 32'h000B_0000;
  localparam logic [31:0] BOT1 = 32'h000B_0006;
  localparam logic [31:0] TOP2 = 32'h000C_0010;
  localparam logic [31:0] BOT2 = 32'h000C_0012;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        lcdEnable = 1'b0;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic        memRspErr = 1'b0;
  logic [15:0] memRspData = '0;
  logic        pixValid;
  logic        pixReady = 1'b1;
  logic [15:0] pixData;
  logic [1:0]  srcSel;
  logic        irq;

  int tests = 0, fails = 0, cyc = 0;
  int expIdx = 0, pixCount = 0, reqCount = 0;
  bit benchTwo = 1, blkIeTb = 1, errIeTb = 1;
  bit stallPix = 0, stallReq = 0, injErr = 0;
  logic [31:0] errAddr = '0;
  bit havePend = 0, endPending = 0, errPending = 0;
  int endKind = 0;
  logic [31:0] pendAddr = '0;

  always #2 clk = ~clk;

  lcd_frame_dma u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lcdEnable(lcdEnable),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspErr(memRspErr), .memRspData(memRspData),
    .pixValid(pixValid), .pixReady(pixReady), .pixData(pixData),
    .srcSel(srcSel), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] memWord(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'hC3A5;
  endfunction

  function automatic logic [31:0] expAddr(input int idx);
    int p;
    if (benchTwo) begin
      p = idx % 6;
      return (p < 4) ? TOP1 + 32'(2*p) : TOP2 + 32'(2*(p-4));
    end
    p = idx % 4;
    return TOP1 + 32'(2*p);
  endfunction

  // 0: not an end, 1: end of buffer 1, 2: end of buffer 2
  function automatic int endOf(input int idx);
    if (benchTwo) return (idx % 6 == 3) ? 1 : (idx % 6 == 5) ? 2 : 0;
    return (idx % 4 == 3) ? 1 : 0;
  endfunction

  // all port activity sampled and driven on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (endPending) begin
        check(irq == blkIeTb, "R8 irq after buffer end", irq, blkIeTb);
        check(regRdData[endKind == 1 ? 3 : 4] == 1'b1, "R7 end flag set",
              regRdData, 32'(endKind));
        endPending = 0;
      end else if (errPending) begin
        check(irq == errIeTb, "R10 irq after error", irq, errIeTb);
        check(regRdData[5] == 1'b1, "R10 error flag", regRdData, 32'h20);
        errPending = 0;
      end else if (irq) begin
        check(1'b0, "R8 stray irq", irq, 0);
      end
      pixReady = stallPix ? (cyc % 3 != 0) : 1'b1;
      if (pixValid && memReqValid) check(1'b0, "R9 request while output pending", 1, 0);
      if (pixValid && pixReady) begin
        check(pixData == memWord(expAddr(expIdx)), "R4 R5 R6 pixel word",
              pixData, memWord(expAddr(expIdx)));
        check(regRdData[4:3] == 2'b00, "R7 flags cleared by next read",
              regRdData, 0);
        if (endOf(expIdx) != 0) begin
          endPending = 1;
          endKind = endOf(expIdx);
        end
        expIdx++;
        pixCount++;
      end
      memRspValid = 1'b0;
      memRspErr   = 1'b0;
      if (havePend) begin
        memRspValid = 1'b1;
        memRspData  = memWord(pendAddr);
        memRspErr   = injErr && (pendAddr == errAddr);
        if (memRspErr) errPending = 1;
        havePend = 0;
      end
      memReqReady = stallReq ? (cyc % 4 != 1) : 1'b1;
      if (memReqValid && memReqReady) begin
        havePend = 1;
        pendAddr = memReqAddr;
        reqCount++;
      end
    end
  end

  task automatic writeReg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = '0;
  endtask

  task automatic readCheck(input logic [3:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData == exp, req, regRdData, exp);
    regAddr = '0;
  endtask

  task automatic waitPix(input int n);
    int target = pixCount + n;
    for (int i = 0; i < 3000 && pixCount < target; i++) @(negedge clk);
  endtask

  task automatic startRun;
    @(negedge clk);
    expIdx = 0;
    lcdEnable = 1'b1;
  endtask

  task automatic stopRun;
    @(negedge clk);
    lcdEnable = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    int pc, rc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(memReqValid == 0 && pixValid == 0 && irq == 0, "R1 outputs idle",
          {memReqValid, pixValid, irq}, 0);
    check(regRdData == 0 && srcSel == 0, "R1 control word", regRdData, 0);
    rstN = 1'b1;

    // R2 control field layout, R12 selector
    writeReg(4'd0, 16'hFFFF);
    readCheck(4'd0, 16'h00C7, "R2 read-only bits ignored");
    check(srcSel == 2'd3, "R12 source select", srcSel, 3);
    writeReg(4'd1, TOP1[31:16]); writeReg(4'd2, TOP1[15:0]);
    writeReg(4'd3, BOT1[31:16]); writeReg(4'd4, BOT1[15:0]);
    writeReg(4'd5, TOP2[31:16]); writeReg(4'd6, TOP2[15:0]);
    writeReg(4'd7, BOT2[31:16]); writeReg(4'd8, BOT2[15:0]);
    readCheck(4'd1, TOP1[31:16], "R2 first1 hi");
    readCheck(4'd2, TOP1[15:0],  "R2 first1 lo");
    readCheck(4'd3, BOT1[31:16], "R2 last1 hi");
    readCheck(4'd4, BOT1[15:0],  "R2 last1 lo");
    readCheck(4'd5, TOP2[31:16], "R2 first2 hi");
    readCheck(4'd6, TOP2[15:0],  "R2 first2 lo");
    readCheck(4'd7, BOT2[31:16], "R2 last2 hi");
    readCheck(4'd8, BOT2[15:0],  "R2 last2 lo");
    writeReg(4'd0, 16'h0047);
    check(srcSel == 2'd1, "R12 source select", srcSel, 1);

    // R3 nothing before enable
    repeat (10) @(negedge clk);
    check(reqCount == 0, "R3 no read before enable", reqCount, 0);

    // R5 dual-buffer ping-pong with interrupts
    benchTwo = 1; blkIeTb = 1;
    startRun();
    waitPix(20);
    check(expIdx >= 20, "R5 dual-buffer words delivered", expIdx, 20);

    // R11 stop on enable low
    pc = pixCount;
    stopRun();
    check(pixCount - pc <= 1, "R11 at most one word after disable", pixCount - pc, 1);
    rc = reqCount;
    repeat (10) @(negedge clk);
    check(reqCount == rc && !memReqValid, "R11 requests stop", reqCount, rc);

    // R9 both sides throttled, buffer interrupt off
    writeReg(4'd0, 16'h0005);
    blkIeTb = 0; stallPix = 1; stallReq = 1;
    startRun();
    waitPix(14);
    check(expIdx >= 14, "R9 throttled words delivered", expIdx, 14);
    stopRun();
    stallPix = 0; stallReq = 0;

    // R6 single-buffer wrap
    writeReg(4'd0, 16'h0002);
    benchTwo = 0; blkIeTb = 1;
    startRun();
    waitPix(12);
    check(expIdx >= 12, "R6 single-buffer words delivered", expIdx, 12);
    stopRun();

    // R10 bus error on the third word of buffer 1
    writeReg(4'd0, 16'h0007);
    benchTwo = 1; errIeTb = 1; injErr = 1; errAddr = TOP1 + 32'd4;
    pc = pixCount; rc = reqCount;
    startRun();
    repeat (40) @(negedge clk);
    check(pixCount - pc == 2, "R10 no pixel for failed word", pixCount - pc, 2);
    check(reqCount - rc == 3, "R10 reads stop after error", reqCount - rc, 3);
    stopRun();
    injErr = 0;
    readCheck(4'd0, 16'h0027, "R10 error flag held while idle");

    // R11 restart from buffer 1 clears the error flag
    startRun();
    waitPix(6);
    check(expIdx >= 6, "R11 restart words", expIdx, 6);
    check(regRdData[5] == 1'b0, "R11 error flag cleared", regRdData, 0);
    stopRun();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule